// File: doc/BRIEF.md
# Length-Aware Transmit/Receive Byte Buffer

This block is a byte-wide staging buffer that sits between a host register interface and a bit serializer. It has 16 bytes of storage, and one packet can carry up to 40 payload bytes, so the storage acts as a FIFO. The host must refill it while a long packet is going out. On the transmit side, the host programs a payload length, writes bytes and pulses a start input. The serializer then pulls bytes one at a time until the programmed count has been consumed. The last byte is marked and a completion pulse is raised.

In the receive direction the roles swap: a deserializer pushes incoming bytes and the host drains them from a show-ahead read port. It must do so in time, or bytes are lost and a sticky overflow error is raised.

Three level flags (empty, at-or-below threshold, full) each feed an interrupt request through a mask bit, so the host can top up or drain at the right moments. If the serializer asks for a byte that has not been loaded, the packet is aborted and a sticky underrun error is raised.

Top module: `pkt_fifo_buf`

## Requirements
- R1: After reset the buffer is empty (level 0, empty and low flags set, full clear), no packet is in progress, both error bits are clear, the programmed length is 0 and all pulse outputs are low.
- R2: A length write while no packet is in progress stores the written value, or 40 if the value is larger. A length write while a packet is in progress is ignored.
- R3: In transmit mode (`mode_rx`=0) a host write stores its byte when the buffer is not full. A host write into a full buffer is dropped and the level is unchanged. Stored bytes leave in the order they were written.
- R4: A start pulse in transmit mode with no packet in progress does the following. If the length is non-zero it begins a packet of that many bytes. If the length is zero it raises `tx_done` on the next cycle with no packet begun. A start pulse during a packet is ignored.
- R5: A serializer request during a packet, with the buffer not empty, removes the oldest byte and presents it on `ser_data` with `ser_valid` high one cycle later. On the byte that completes the programmed length, `ser_last` and `tx_done` are high in that same cycle and the packet ends.
- R6: A packet longer than the storage completes with every byte in order when the host keeps writing while bytes are drained.
- R7: A serializer request during a packet while the buffer is empty is an underrun. On the next cycle `underrun_err` is set and stays set, the packet is abandoned, the buffer is emptied and no byte is presented.
- R8: In receive mode (`mode_rx`=1) an `rx_wr_en` byte is stored when the buffer is not full. `host_rd_data` always shows the oldest stored byte, and `host_rd_en` removes it when the buffer is not empty.
- R9: In receive mode an `rx_wr_en` into a full buffer sets the sticky `overflow_err`, and the byte is discarded.
- R10: `level` gives the stored byte count. `flag_empty` is level==0, `flag_low` is level<=8 and `flag_full` is level==16.
- R11: `irq` is high exactly when a flag is set whose mask bit is set: mask bit 0 for empty, bit 1 for low, bit 2 for full.
- R12: `err_clr` clears both sticky error bits. A new error event in the same cycle wins over the clear.
- R13: A change of `mode_rx` empties the buffer and abandons any packet in progress without setting an error.
- R14: In receive mode `host_wr_en`, `tx_start` and `ser_rd_req` have no effect. In transmit mode `rx_wr_en` and `host_rd_en` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rx | input | 1 | 0 transmit direction, 1 receive direction |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 6 | Length value to write |
| tx_start | input | 1 | Start a transmit packet |
| host_wr_en | input | 1 | Host byte write (transmit mode) |
| host_wr_data | input | 8 | Host write byte |
| host_rd_en | input | 1 | Host byte read/remove (receive mode) |
| host_rd_data | output | 8 | Oldest stored byte (show-ahead) |
| rx_wr_en | input | 1 | Deserializer byte write (receive mode) |
| rx_wr_data | input | 8 | Deserializer byte |
| ser_rd_req | input | 1 | Serializer requests next byte |
| ser_valid | output | 1 | `ser_data` holds a delivered byte |
| ser_data | output | 8 | Byte delivered to the serializer |
| ser_last | output | 1 | Delivered byte is the final one of the packet |
| tx_busy | output | 1 | Transmit packet in progress |
| tx_done | output | 1 | Packet completion pulse |
| cfg_len | output | 6 | Programmed payload length |
| level | output | 5 | Stored byte count |
| flag_empty | output | 1 | Buffer empty |
| flag_low | output | 1 | Level at or below threshold |
| flag_full | output | 1 | Buffer full |
| irq_mask | input | 3 | Interrupt enables {full, low, empty} |
| irq | output | 1 | Combined interrupt request |
| err_clr | input | 1 | Clear sticky error bits |
| underrun_err | output | 1 | Sticky underrun error |
| overflow_err | output | 1 | Sticky receive overflow error |

## Verification
The hardest state to reach from the ports is a 40-byte packet that actually wraps the storage pointers several times while the level swings around the threshold. The stimulus gets there by prefilling 16 bytes, then requesting bytes on two cycles out of three while writing whenever the reference queue shows room. Underrun needs the opposite: a programmed length larger than what was loaded, followed by continuous requests. A long randomized phase then mixes mode switches, clears that coincide with new errors, and starts issued during a packet. A queue-based model is compared against the ports on every cycle.

// File: rtl/pkb_pkg.sv
package pkb_pkg;

  typedef enum int unsigned {
    FLG_EMPTY = 0,
    FLG_LOW   = 1,
    FLG_FULL  = 2
  } flag_idx_e;

  // saturate a requested payload length to the largest legal packet
  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

  // level-derived status vector, indexed by flag_idx_e
  function automatic logic [2:0] level_flags(input int unsigned cnt,
                                             input int unsigned thr,
                                             input int unsigned dep);
    logic [2:0] f;
    f            = '0;
    f[FLG_EMPTY] = (cnt == 0);
    f[FLG_LOW]   = (cnt <= thr);
    f[FLG_FULL]  = (cnt >= dep);
    return f;
  endfunction

  // circular pointer advance for a storage of arbitrary depth
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned dep);
    return (p == dep - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/pkb_store.sv
module pkb_store import pkb_pkg::*; #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= AW'(ptr_next(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(ptr_next(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  assign head = mem[rd_ptr];

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  assert_push_has_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != DEPTH_C));
  assert_pop_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  assert_flush_empties_R13: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

endmodule

// File: rtl/pkb_txctl.sv
module pkb_txctl import pkb_pkg::*; #(
  parameter int MAX_LEN = 40,
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_tx,
  input  logic          abort,
  input  logic          len_we,
  input  logic [LW-1:0] len_wdata,
  input  logic          start,
  input  logic          rd_req,
  input  logic          buf_empty,
  output logic [LW-1:0] cfg_len,
  output logic          busy,
  output logic          pop,
  output logic          underrun_evt,
  output logic          ser_valid,
  output logic          ser_last,
  output logic          done
);
  localparam logic [LW-1:0] MAXL = LW'(MAX_LEN);

  logic [LW-1:0] remaining;
  logic          req_live;

  assign req_live     = !abort && en_tx && busy && rd_req;
  assign pop          = req_live && !buf_empty;
  assign underrun_evt = req_live && buf_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      remaining <= '0;
      ser_valid <= 1'b0;
      ser_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      ser_valid <= 1'b0;
      ser_last  <= 1'b0;
      done      <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (pop) begin
          remaining <= remaining - 1'b1;
          ser_valid <= 1'b1;
          if (remaining == LW'(1)) begin
            ser_last <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b1;
          end
        end else if (underrun_evt) begin
          busy <= 1'b0;
        end
      end else if (start && en_tx) begin
        if (cfg_len == '0) begin
          done <= 1'b1;
        end else begin
          busy      <= 1'b1;
          remaining <= cfg_len;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cfg_len <= '0;
    else if (len_we && !busy) cfg_len <= LW'(clamp_len(int'(len_wdata), MAX_LEN));
  end

  assert_len_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_len <= MAXL);
  assert_last_ends_packet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_last |-> (ser_valid && done && !busy));
  assert_underrun_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> (!busy && !ser_valid));
  assert_len_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_len));

endmodule

// File: rtl/pkb_flags.sv
module pkb_flags import pkb_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [2:0]    irq_mask,
  input  logic          underrun_evt,
  input  logic          overflow_evt,
  input  logic          err_clr,
  output logic [2:0]    flags,
  output logic          irq,
  output logic          und_err,
  output logic          ovf_err
);
  assign flags = level_flags(int'(count), THRESH, DEPTH);
  assign irq   = |(flags & irq_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      und_err <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      und_err <= underrun_evt || (und_err && !err_clr);
      ovf_err <= overflow_evt || (ovf_err && !err_clr);
    end
  end

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_evt |=> ovf_err);
  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> und_err);
  assert_errors_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !err_clr) |=> ovf_err);
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[FLG_EMPTY] && flags[FLG_FULL]));

endmodule

// File: rtl/pkt_fifo_buf.sv
module pkt_fifo_buf import pkb_pkg::*; #(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int MAX_LEN = 40,
  parameter int THRESH  = 8,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_rx,
  input  logic          len_we,
  input  logic [LW-1:0] len_wdata,
  input  logic          tx_start,
  input  logic          host_wr_en,
  input  logic [DW-1:0] host_wr_data,
  input  logic          host_rd_en,
  output logic [DW-1:0] host_rd_data,
  input  logic          rx_wr_en,
  input  logic [DW-1:0] rx_wr_data,
  input  logic          ser_rd_req,
  output logic          ser_valid,
  output logic [DW-1:0] ser_data,
  output logic          ser_last,
  output logic          tx_busy,
  output logic          tx_done,
  output logic [LW-1:0] cfg_len,
  output logic [CW-1:0] level,
  output logic          flag_empty,
  output logic          flag_low,
  output logic          flag_full,
  input  logic [2:0]    irq_mask,
  output logic          irq,
  input  logic          err_clr,
  output logic          underrun_err,
  output logic          overflow_err
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          mode_q, mode_chg, flush;
  logic          buf_empty, buf_full;
  logic          push_req, push, pop, tx_pop, underrun_evt, overflow_evt;
  logic [DW-1:0] push_data, head;
  logic [2:0]    flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_rx;
  end

  assign mode_chg  = mode_rx ^ mode_q;
  assign flush     = mode_chg || underrun_evt;
  assign buf_empty = (level == '0);
  assign buf_full  = (level == DEPTH_C);

  assign push_req     = mode_rx ? rx_wr_en : host_wr_en;
  assign push_data    = mode_rx ? rx_wr_data : host_wr_data;
  assign push         = push_req && !buf_full && !flush;
  assign pop          = mode_rx ? (host_rd_en && !buf_empty && !flush) : tx_pop;
  assign overflow_evt = mode_rx && rx_wr_en && buf_full;

  pkb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (push_data),
    .pop   (pop),
    .flush (flush),
    .head  (head),
    .count (level)
  );

  pkb_txctl #(.MAX_LEN(MAX_LEN)) u_txctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_tx        (!mode_rx),
    .abort        (mode_chg),
    .len_we       (len_we),
    .len_wdata    (len_wdata),
    .start        (tx_start),
    .rd_req       (ser_rd_req),
    .buf_empty    (buf_empty),
    .cfg_len      (cfg_len),
    .busy         (tx_busy),
    .pop          (tx_pop),
    .underrun_evt (underrun_evt),
    .ser_valid    (ser_valid),
    .ser_last     (ser_last),
    .done         (tx_done)
  );

  pkb_flags #(.DEPTH(DEPTH), .THRESH(THRESH)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .count        (level),
    .irq_mask     (irq_mask),
    .underrun_evt (underrun_evt),
    .overflow_evt (overflow_evt),
    .err_clr      (err_clr),
    .flags        (flags),
    .irq          (irq),
    .und_err      (underrun_err),
    .ovf_err      (overflow_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ser_data <= '0;
    else if (tx_pop) ser_data <= head;
  end

  assign host_rd_data = head;
  assign flag_empty   = flags[FLG_EMPTY];
  assign flag_low     = flags[FLG_LOW];
  assign flag_full    = flags[FLG_FULL];

  assert_overflow_keeps_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_evt && !host_rd_en && !mode_chg) |=> (level == DEPTH_C));
  assert_rx_ignores_tx_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rx && mode_q) |-> !tx_pop);
  assert_pop_gives_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> ser_valid);
  assert_mode_switch_aborts_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (!tx_busy && level == '0));

endmodule

// File: tb/sim_pkt_fifo_buf.sv
module sim_pkt_fifo_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_rx = 1'b0, len_we = 1'b0, tx_start = 1'b0;
  logic [5:0] len_wdata = '0;
  logic       host_wr_en = 1'b0, host_rd_en = 1'b0, rx_wr_en = 1'b0, ser_rd_req = 1'b0;
  logic [7:0] host_wr_data = '0, rx_wr_data = '0;
  logic [2:0] irq_mask = 3'b000;
  logic       err_clr = 1'b0;
  logic [7:0] host_rd_data, ser_data;
  logic       ser_valid, ser_last, tx_busy, tx_done;
  logic [5:0] cfg_len;
  logic [4:0] level;
  logic       flag_empty, flag_low, flag_full, irq, underrun_err, overflow_err;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  pkt_fifo_buf u0 (.*);

  // ---------------- reference model ----------------
  byte unsigned q[$];
  bit m_mode, m_busy, m_sv, m_last, m_done, m_uerr, m_oerr;
  int m_rem, m_len;
  byte unsigned m_sdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_mode = 0; m_busy = 0; m_sv = 0; m_last = 0; m_done = 0;
      m_uerr = 0; m_oerr = 0; m_rem = 0; m_len = 0; m_sdata = 0;
    end else begin
      bit chg, full, empty, live, und, txpop, flush, ovf, was_busy;
      chg   = (mode_rx != m_mode);
      m_mode = mode_rx;
      full  = (q.size() == 16);
      empty = (q.size() == 0);
      live  = !chg && !mode_rx && m_busy && ser_rd_req;
      und   = live && empty;
      txpop = live && !empty;
      flush = chg || und;
      ovf   = mode_rx && rx_wr_en && full;
      was_busy = m_busy;
      m_sv = 0; m_last = 0; m_done = 0;
      if (chg) m_busy = 0;
      else if (m_busy) begin
        if (txpop) begin
          m_sdata = q[0]; m_sv = 1;
          if (m_rem == 1) begin m_last = 1; m_busy = 0; m_done = 1; end
          m_rem--;
        end else if (und) m_busy = 0;
      end else if (tx_start && !mode_rx) begin
        if (m_len == 0) m_done = 1;
        else begin m_busy = 1; m_rem = m_len; end
      end
      if (len_we && !was_busy) m_len = (len_wdata > 40) ? 40 : int'(len_wdata);
      if (flush) q.delete();
      else begin
        if (txpop || (mode_rx && host_rd_en && !empty)) void'(q.pop_front());
        if ((mode_rx ? rx_wr_en : host_wr_en) && !full)
          q.push_back(mode_rx ? rx_wr_data : host_wr_data);
      end
      m_uerr = und || (m_uerr && !err_clr);
      m_oerr = ovf || (m_oerr && !err_clr);
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int n;
      n = q.size();
      chk("R10", "level", level, n);
      chk("R10", "flag_empty", flag_empty, n == 0);
      chk("R10", "flag_low", flag_low, n <= 8);
      chk("R10", "flag_full", flag_full, n == 16);
      chk("R11", "irq", irq, (irq_mask[0] && n == 0) || (irq_mask[1] && n <= 8) || (irq_mask[2] && n == 16));
      chk("R4", "tx_busy", tx_busy, m_busy);
      chk("R5", "tx_done", tx_done, m_done);
      chk("R5", "ser_valid", ser_valid, m_sv);
      if (m_sv) begin
        chk("R3", "ser_data order", ser_data, m_sdata);
        chk("R5", "ser_last", ser_last, m_last);
      end
      chk("R2", "cfg_len", cfg_len, m_len);
      chk("R7", "underrun_err", underrun_err, m_uerr);
      chk("R9", "overflow_err", overflow_err, m_oerr);
      if (n > 0) chk("R8", "host_rd_data", host_rd_data, q[0]);
    end
  end

  task automatic tick();
    @(negedge clk);
    len_we = 0; tx_start = 0; host_wr_en = 0; host_rd_en = 0;
    rx_wr_en = 0; ser_rd_req = 0; err_clr = 0;
  endtask

  task automatic set_len(input int v);
    len_we = 1; len_wdata = 6'(v); tick();
  endtask

  task automatic hwrite(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      host_wr_en = 1; host_wr_data = 8'(base + i); tick();
    end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin ser_rd_req = 1; tick(); end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", "level", level, 0);
    chk("R1", "empty", flag_empty, 1);
    chk("R1", "full", flag_full, 0);
    chk("R1", "busy", tx_busy, 0);
    chk("R1", "errors", {underrun_err, overflow_err}, 0);
    chk("R1", "cfg_len", cfg_len, 0);
    chk("R1", "pulses", {ser_valid, tx_done}, 0);
    rst_n = 1; tick();
    irq_mask = 3'b001;
    // R2 clamp
    set_len(45);
    chk("R2", "clamped length", cfg_len, 40);
    // short packet
    set_len(5); hwrite(5, 8'h10);
    tx_start = 1; tick();
    drain(7);
    chk("R5", "buffer drained", level, 0);
    // R4 zero length
    set_len(0); tx_start = 1; tick();
    chk("R4", "zero-length done", tx_done, 1);
    tick();
    // R3 overfill
    irq_mask = 3'b100;
    hwrite(18, 8'h40);
    chk("R3", "overfill level", level, 16);
    set_len(16); tx_start = 1; tick();
    drain(17);
    // R6 long packet with refill
    irq_mask = 3'b010;
    set_len(40); hwrite(16, 8'h80);
    tx_start = 1; tick();
    begin
      int sent = 16;
      for (int i = 0; i < 150; i++) begin
        ser_rd_req = (i % 3 != 0);
        if (q.size() < 16 && sent < 40) begin
          host_wr_en = 1; host_wr_data = 8'(8'h80 + sent); sent++;
        end
        tick();
      end
    end
    chk("R6", "long packet finished", tx_busy, 0);
    chk("R6", "no underrun", underrun_err, 0);
    // R7 underrun
    set_len(10); hwrite(3, 8'hA0);
    tx_start = 1; tick();
    drain(6);
    chk("R7", "underrun sticky", underrun_err, 1);
    err_clr = 1; tick();
    chk("R12", "cleared", underrun_err, 0);
    // R2/R4 ignored while busy
    set_len(4); hwrite(2, 8'hB0);
    tx_start = 1; tick();
    len_we = 1; len_wdata = 6'd9; tx_start = 1; tick();
    chk("R2", "length held while busy", cfg_len, 4);
    hwrite(2, 8'hB2); drain(5);
    // R13 abort by mode change
    set_len(8); hwrite(4, 8'hC0);
    tx_start = 1; tick(); drain(2);
    mode_rx = 1; tick();
    chk("R13", "abort busy", tx_busy, 0);
    chk("R13", "abort level", level, 0);
    chk("R13", "no error", underrun_err, 0);
    // receive mode, R14 ignored inputs
    irq_mask = 3'b111;
    host_wr_en = 1; host_wr_data = 8'hEE; tx_start = 1; ser_rd_req = 1; tick();
    chk("R14", "tx inputs ignored in rx", level, 0);
    for (int i = 0; i < 20; i++) begin rx_wr_en = 1; rx_wr_data = 8'(8'hD0 + i); tick(); end
    chk("R9", "overflow", overflow_err, 1);
    chk("R9", "level held", level, 16);
    chk("R8", "head byte", host_rd_data, 8'hD0);
    for (int i = 0; i < 5; i++) begin host_rd_en = 1; tick(); end
    chk("R8", "head after reads", host_rd_data, 8'hD5);
    for (int i = 0; i < 5; i++) begin rx_wr_en = 1; rx_wr_data = 8'(8'hF0 + i); tick(); end
    rx_wr_en = 1; err_clr = 1; tick();
    chk("R12", "event wins over clear", overflow_err, 1);
    err_clr = 1; tick();
    chk("R12", "clear", overflow_err, 0);
    // back to transmit: rx inputs ignored
    mode_rx = 0; tick();
    rx_wr_en = 1; host_rd_en = 1; tick();
    chk("R14", "rx inputs ignored in tx", level, 0);
    // randomized mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) mode_rx = ~mode_rx;
      len_we = ($urandom_range(0, 19) == 0); len_wdata = 6'($urandom_range(0, 63));
      tx_start = ($urandom_range(0, 9) == 0);
      host_wr_en = ($urandom_range(0, 2) != 0); host_wr_data = 8'($urandom);
      rx_wr_en = ($urandom_range(0, 2) != 0); rx_wr_data = 8'($urandom);
      host_rd_en = ($urandom_range(0, 2) == 0);
      ser_rd_req = ($urandom_range(0, 1) == 0);
      err_clr = ($urandom_range(0, 29) == 0);
      irq_mask = 3'($urandom);
      tick();
    end
    summary();
    $finish;
  end
endmodule